// File: doc/BRIEF.md
# Wake Event Controller

The block gathers wake requests from three kinds of source and turns them into one active-low, open-drain wake request. The sources are a set of general-purpose input pins, each with its own choice of triggering edge; a set of fan tachometer inputs; and a match between bytes arriving from a keyboard and one programmable scan code. Each source has a sticky status flag and its own enable flag. A pending status whose enable is set contributes to a summary flag. A single global enable decides whether that summary may pull the wake pin low.

Software reaches the block through a small synchronous register port with eight byte-wide locations. Status locations are cleared by writing ones. The enables, the per-pin edge selection and the scan code are plain read/write locations. Status keeps latching while the global enable is off, so a wake cause is never lost while the output is masked. The scan-code location belongs to the standby power domain: it survives the main-power reset and is cleared only by the standby power-on reset.

Top module: `wake_event_ctrl`

## Requirements
- R1: While the global enable (bit 0 of location 7) is 0, `wakeOe` stays 0 whatever the status and enable flags hold.
- R2: With the global enable at 1, `wakeOe` is 1 (pin pulled low) in every cycle in which some status bit and its enable bit are both 1. The block never drives the pin high; `wakeOe` low means released.
- R3: Status bits latch their source events while the global enable is 0.
- R4: General-purpose input i reaches status location 0 bit i. Polarity location 4 bit i selects the edge: 0 means rising, 1 means falling. Inputs pass a two-flop synchronizer, so the status bit sets on the third rising clock edge after the input changes.
- R5: With bit i of the both-edge location 5 set, input i sets its status bit on both rising and falling edges, whatever its polarity bit holds.
- R6: Writing a 1 to a bit of status location 0 or 1 clears that bit. Writing a 0 leaves the bit unchanged, and a status bit never falls without such a write.
- R7: Location 6 holds an 8-bit scan code. A keyboard byte presented with `kbdValid` that equals it sets status location 1 bit 5 on the next clock edge. The enable for this source is location 3 bit 5.
- R8: Bit 7 of location 7 reads the summary: the OR over all status bits ANDed with their enables, enables in location 2 (inputs) and location 3 (tachometer and keyboard). It stays 1 until every enabled pending status bit is cleared.
- R9: Tachometer input j sets status location 1 bit j on its rising edge, after the same synchronizer as R4. Falling edges have no effect. Its enable is location 3 bit j.
- R10: Pulsing `rstMainN` low keeps the scan code and clears every other location. Pulsing `rstStbyN` low also clears the scan code.
- R11: When a source event and a write-1 clear of the same status bit fall in the same cycle, the bit ends up set.
- R12: After reset every location reads 0 and `wakeOe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstMainN | input | 1 | Main-power reset, active low, asynchronous |
| rstStbyN | input | 1 | Standby power-on reset, active low, asynchronous |
| regWrEn | input | 1 | Register write strobe for one cycle |
| regAddr | input | 3 | Register location for read and write |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Read data of the addressed location (combinational) |
| gpioIn | input | NUM_GPIO | General-purpose wake inputs (asynchronous) |
| tachIn | input | NUM_TACH | Fan tachometer inputs (asynchronous) |
| kbdValid | input | 1 | Keyboard byte valid |
| kbdByte | input | 8 | Keyboard byte |
| wakeOe | output | 1 | Wake pin pull-down enable; 1 pulls the pin low |

## Verification
The hardest case to reach from the ports is an event that lands in exactly the cycle in which software clears the same status bit. The synchronized pin paths make that cycle hard to hit, so the bench uses the keyboard path, which has a single register. It presents a matching byte at the same clock edge as the write-1 clear and then reads the bit back. Survival of the scan code across a main-power reset is reached by pulsing the two reset inputs separately and reading the code location after each pulse.

// File: rtl/wake_pkg.sv
package wake_pkg;
  localparam int REG_W  = 8;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] ADDR_STAT0 = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_STAT1 = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_EN0   = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_EN1   = 3'd3;
  localparam logic [ADDR_W-1:0] ADDR_POL   = 3'd4;
  localparam logic [ADDR_W-1:0] ADDR_BOTH  = 3'd5;
  localparam logic [ADDR_W-1:0] ADDR_CODE  = 3'd6;
  localparam logic [ADDR_W-1:0] ADDR_CTL   = 3'd7;

  // bit of status/enable location 1 that carries the keyboard match
  localparam int KBD_BIT = 5;

  typedef struct packed {
    logic wrStat0;
    logic wrStat1;
    logic wrEn0;
    logic wrEn1;
    logic wrPol;
    logic wrBoth;
    logic wrCode;
    logic wrCtl;
  } regStrobeT;
endpackage

// File: rtl/wake_ctrl.sv
module wake_ctrl
  import wake_pkg::*;
(
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  output regStrobeT         strb
);
  always_comb begin
    strb = '0;
    if (regWrEn) begin
      case (regAddr)
        ADDR_STAT0: strb.wrStat0 = 1'b1;
        ADDR_STAT1: strb.wrStat1 = 1'b1;
        ADDR_EN0:   strb.wrEn0   = 1'b1;
        ADDR_EN1:   strb.wrEn1   = 1'b1;
        ADDR_POL:   strb.wrPol   = 1'b1;
        ADDR_BOTH:  strb.wrBoth  = 1'b1;
        ADDR_CODE:  strb.wrCode  = 1'b1;
        ADDR_CTL:   strb.wrCtl   = 1'b1;
        default:    strb = '0;
      endcase
    end
  end
endmodule

// File: rtl/wake_sync.sv
module wake_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] pipe [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < STAGES; s++) pipe[s] <= '0;
    end else begin
      pipe[0] <= din;
      for (int s = 1; s < STAGES; s++) pipe[s] <= pipe[s-1];
    end
  end

  assign dout = pipe[STAGES-1];
endmodule

// File: rtl/wake_dp.sv
module wake_dp
  import wake_pkg::*;
#(
  parameter int NUM_GPIO    = 4,   // at most REG_W
  parameter int NUM_TACH    = 2,   // at most KBD_BIT
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                rstStbyN,
  input  regStrobeT           strb,
  input  logic [REG_W-1:0]    wrData,
  input  logic [ADDR_W-1:0]   rdAddr,
  output logic [REG_W-1:0]    rdData,
  input  logic [NUM_GPIO-1:0] gpioIn,
  input  logic [NUM_TACH-1:0] tachIn,
  input  logic                kbdValid,
  input  logic [7:0]          kbdByte,
  output logic [REG_W-1:0]    stat0,
  output logic [REG_W-1:0]    stat1,
  output logic [7:0]          scanCode,
  output logic                globEn,
  output logic                summary,
  output logic                wakeOe
);
  localparam logic [REG_W-1:0] STAT0_MASK = REG_W'((1 << NUM_GPIO) - 1);
  localparam logic [REG_W-1:0] STAT1_MASK =
    REG_W'((1 << NUM_TACH) - 1) | REG_W'(1 << KBD_BIT);

  // synchronized inputs and their previous values
  logic [NUM_GPIO-1:0] gSync, gPrev, gRise, gFall, gpioHit;
  logic [NUM_TACH-1:0] tSync, tPrev, tachHit;
  logic                kbdHit;

  logic [NUM_GPIO-1:0] gpioPol, gpioBoth;
  logic [REG_W-1:0]    en0, en1;
  logic [REG_W-1:0]    set0, set1, clr0, clr1;

  wake_sync #(.W(NUM_GPIO), .STAGES(SYNC_STAGES)) u_gpioSync (
    .clk(clk), .rstN(rstN), .din(gpioIn), .dout(gSync)
  );
  wake_sync #(.W(NUM_TACH), .STAGES(SYNC_STAGES)) u_tachSync (
    .clk(clk), .rstN(rstN), .din(tachIn), .dout(tSync)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gPrev <= '0;
      tPrev <= '0;
    end else begin
      gPrev <= gSync;
      tPrev <= tSync;
    end
  end

  assign gRise   = gSync & ~gPrev;
  assign gFall   = ~gSync & gPrev;
  assign tachHit = tSync & ~tPrev;
  assign kbdHit  = kbdValid && (kbdByte == scanCode);

  for (genvar i = 0; i < NUM_GPIO; i++) begin : g_edgeSel
    assign gpioHit[i] = gpioBoth[i] ? (gRise[i] | gFall[i])
                                    : (gpioPol[i] ? gFall[i] : gRise[i]);
  end

  always_comb begin
    set0 = '0;
    set0[NUM_GPIO-1:0] = gpioHit;
    set1 = '0;
    set1[NUM_TACH-1:0] = tachHit;
    set1[KBD_BIT] = kbdHit;
    clr0 = strb.wrStat0 ? wrData : '0;
    clr1 = strb.wrStat1 ? wrData : '0;
  end

  // status: an event in the clearing cycle wins
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stat0 <= '0;
      stat1 <= '0;
    end else begin
      stat0 <= ((stat0 & ~clr0) | set0) & STAT0_MASK;
      stat1 <= ((stat1 & ~clr1) | set1) & STAT1_MASK;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      en0      <= '0;
      en1      <= '0;
      gpioPol  <= '0;
      gpioBoth <= '0;
      globEn   <= 1'b0;
    end else begin
      if (strb.wrEn0)  en0      <= wrData & STAT0_MASK;
      if (strb.wrEn1)  en1      <= wrData & STAT1_MASK;
      if (strb.wrPol)  gpioPol  <= wrData[NUM_GPIO-1:0];
      if (strb.wrBoth) gpioBoth <= wrData[NUM_GPIO-1:0];
      if (strb.wrCtl)  globEn   <= wrData[0];
    end
  end

  // standby-domain register
  always_ff @(posedge clk or negedge rstStbyN) begin
    if (!rstStbyN)        scanCode <= '0;
    else if (strb.wrCode) scanCode <= wrData;
  end

  assign summary = (|(stat0 & en0)) | (|(stat1 & en1));
  assign wakeOe  = globEn & summary;

  always_comb begin
    case (rdAddr)
      ADDR_STAT0: rdData = stat0;
      ADDR_STAT1: rdData = stat1;
      ADDR_EN0:   rdData = en0;
      ADDR_EN1:   rdData = en1;
      ADDR_POL:   rdData = REG_W'(gpioPol);
      ADDR_BOTH:  rdData = REG_W'(gpioBoth);
      ADDR_CODE:  rdData = scanCode;
      default:    rdData = {summary, 6'b0, globEn};
    endcase
  end
endmodule

// File: rtl/wake_event_ctrl.sv
module wake_event_ctrl
  import wake_pkg::*;
#(
  parameter int NUM_GPIO    = 4,
  parameter int NUM_TACH    = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstMainN,
  input  logic                rstStbyN,
  input  logic                regWrEn,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic [REG_W-1:0]    regWrData,
  output logic [REG_W-1:0]    regRdData,
  input  logic [NUM_GPIO-1:0] gpioIn,
  input  logic [NUM_TACH-1:0] tachIn,
  input  logic                kbdValid,
  input  logic [7:0]          kbdByte,
  output logic                wakeOe
);
  regStrobeT        strb;
  logic             rstN;
  logic [REG_W-1:0] stat0, stat1;
  logic [7:0]       scanCode;
  logic             globEn, summary;

  // either reset clears the main-domain state
  assign rstN = rstMainN & rstStbyN;

  wake_ctrl u_ctrl (
    .regWrEn(regWrEn), .regAddr(regAddr), .strb(strb)
  );

  wake_dp #(
    .NUM_GPIO(NUM_GPIO), .NUM_TACH(NUM_TACH), .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .clk(clk), .rstN(rstN), .rstStbyN(rstStbyN), .strb(strb),
    .wrData(regWrData), .rdAddr(regAddr), .rdData(regRdData),
    .gpioIn(gpioIn), .tachIn(tachIn), .kbdValid(kbdValid), .kbdByte(kbdByte),
    .stat0(stat0), .stat1(stat1), .scanCode(scanCode), .globEn(globEn),
    .summary(summary), .wakeOe(wakeOe)
  );
endmodule

// File: rtl/wake_event_ctrl_chk.sv
module wake_event_ctrl_chk
  import wake_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              regWrEn,
  input logic [ADDR_W-1:0] regAddr,
  input logic              kbdValid,
  input logic [7:0]        kbdByte,
  input logic [REG_W-1:0]  stat0,
  input logic [REG_W-1:0]  stat1,
  input logic [7:0]        scanCode,
  input logic              globEn,
  input logic              summary,
  input logic              wakeOe
);
  // R1
  glob_off_no_wake_chk: assert property (@(posedge clk) disable iff (!rstN)
    !globEn |-> !wakeOe);

  // R6
  stat0_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(regWrEn && regAddr == ADDR_STAT0) |=> (($past(stat0) & ~stat0) == '0));

  // R6
  stat1_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(regWrEn && regAddr == ADDR_STAT1) |=> (($past(stat1) & ~stat1) == '0));

  // R7
  kbd_match_sets_chk: assert property (@(posedge clk) disable iff (!rstN)
    (kbdValid && kbdByte == scanCode) |=> stat1[KBD_BIT]);

  // R8
  summary_drop_on_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(summary) |-> $past(regWrEn));
endmodule

bind wake_event_ctrl wake_event_ctrl_chk i_chk (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
  .kbdValid(kbdValid), .kbdByte(kbdByte), .stat0(stat0), .stat1(stat1),
  .scanCode(scanCode), .globEn(globEn), .summary(summary), .wakeOe(wakeOe)
);

// File: tb/test_wake_event_ctrl.sv
`timescale 1ns/1ps
module test_wake_event_ctrl;
  import wake_pkg::*;
  localparam int NG = 4;
  localparam int NT = 2;
  localparam int NV = 54;

  // vector: {req[3:0], kind[1:0], addr[2:0], data[7:0]}
  // kind 0 write, 1 read check, 2 drive (addr 0 gpio, 1 tach, 2 kbd byte), 3 wake check
  localparam logic [16:0] VEC [NV] = '{
    {4'd12,2'd1,3'd7,8'h00}, {4'd12,2'd1,3'd0,8'h00}, {4'd12,2'd1,3'd6,8'h00}, // R12
    {4'd12,2'd3,3'd0,8'h00},
    {4'd4, 2'd2,3'd0,8'h01}, {4'd3, 2'd1,3'd0,8'h01},                          // R4 R3
    {4'd1, 2'd3,3'd0,8'h00}, {4'd1, 2'd0,3'd2,8'h01}, {4'd1, 2'd3,3'd0,8'h00}, // R1
    {4'd8, 2'd1,3'd7,8'h80},                                                   // R8
    {4'd2, 2'd0,3'd7,8'h01}, {4'd2, 2'd3,3'd0,8'h01}, {4'd8, 2'd1,3'd7,8'h81}, // R2
    {4'd6, 2'd0,3'd0,8'h00}, {4'd6, 2'd1,3'd0,8'h01},                          // R6
    {4'd6, 2'd0,3'd0,8'h01}, {4'd6, 2'd1,3'd0,8'h00}, {4'd2, 2'd3,3'd0,8'h00},
    {4'd4, 2'd2,3'd0,8'h00}, {4'd4, 2'd1,3'd0,8'h00},                          // R4 falling ignored
    {4'd4, 2'd0,3'd4,8'h02}, {4'd4, 2'd2,3'd0,8'h02}, {4'd4, 2'd1,3'd0,8'h00},
    {4'd4, 2'd2,3'd0,8'h00}, {4'd4, 2'd1,3'd0,8'h02},
    {4'd5, 2'd0,3'd5,8'h04}, {4'd5, 2'd2,3'd0,8'h04}, {4'd5, 2'd1,3'd0,8'h06}, // R5
    {4'd5, 2'd0,3'd0,8'h04}, {4'd5, 2'd1,3'd0,8'h02},
    {4'd5, 2'd2,3'd0,8'h00}, {4'd5, 2'd1,3'd0,8'h06},
    {4'd8, 2'd0,3'd2,8'h06}, {4'd8, 2'd0,3'd0,8'h02}, {4'd8, 2'd1,3'd7,8'h81}, // R8
    {4'd8, 2'd0,3'd0,8'h04}, {4'd8, 2'd1,3'd7,8'h01},
    {4'd9, 2'd2,3'd1,8'h01}, {4'd9, 2'd1,3'd1,8'h01}, {4'd9, 2'd3,3'd0,8'h00}, // R9
    {4'd9, 2'd0,3'd3,8'h01}, {4'd9, 2'd3,3'd0,8'h01},
    {4'd9, 2'd0,3'd1,8'h01}, {4'd9, 2'd3,3'd0,8'h00},
    {4'd7, 2'd0,3'd6,8'h5A}, {4'd7, 2'd1,3'd6,8'h5A},                          // R7
    {4'd7, 2'd2,3'd2,8'h5B}, {4'd7, 2'd1,3'd1,8'h00},
    {4'd7, 2'd2,3'd2,8'h5A}, {4'd7, 2'd1,3'd1,8'h20},
    {4'd7, 2'd0,3'd3,8'h20}, {4'd7, 2'd3,3'd0,8'h01},
    {4'd9, 2'd2,3'd1,8'h00}, {4'd9, 2'd1,3'd1,8'h20}                           // R9 falling ignored
  };

  logic             clk = 1'b0;
  logic             rstMainN, rstStbyN;
  logic             regWrEn;
  logic [2:0]       regAddr;
  logic [7:0]       regWrData, regRdData;
  logic [NG-1:0]    gpioIn;
  logic [NT-1:0]    tachIn;
  logic             kbdValid;
  logic [7:0]       kbdByte;
  logic             wakeOe;
  int               checks = 0;
  int               errors = 0;

  always #4 clk = ~clk;

  wake_event_ctrl #(.NUM_GPIO(NG), .NUM_TACH(NT)) i_wake_event_ctrl (
    .clk(clk), .rstMainN(rstMainN), .rstStbyN(rstStbyN), .regWrEn(regWrEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .gpioIn(gpioIn), .tachIn(tachIn), .kbdValid(kbdValid), .kbdByte(kbdByte),
    .wakeOe(wakeOe)
  );

  task automatic chk(input int req, input string what,
                     input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d %s actual=%02h expected=%02h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rdChk(input int req, input logic [2:0] a, input logic [7:0] exp);
    @(negedge clk);
    regAddr = a;
    #1 chk(req, "read", regRdData, exp);
  endtask

  task automatic wakeChk(input int req, input logic exp);
    @(negedge clk);
    #1 chk(req, "wake", {7'b0, wakeOe}, {7'b0, exp});
  endtask

  task automatic sendKbd(input logic [7:0] b);
    @(negedge clk);
    kbdValid = 1'b1; kbdByte = b;
    @(negedge clk);
    kbdValid = 1'b0;
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R0 watchdog actual=timeout expected=finish");
    finishRun();
  end

  initial begin
    rstMainN = 1'b0; rstStbyN = 1'b0; regWrEn = 1'b0; regAddr = '0;
    regWrData = '0; gpioIn = '0; tachIn = '0; kbdValid = 1'b0; kbdByte = '0;
    repeat (3) @(negedge clk);
    rstMainN = 1'b1; rstStbyN = 1'b1;

    for (int v = 0; v < NV; v++) begin
      logic [3:0] req;
      logic [1:0] kind;
      logic [2:0] a;
      logic [7:0] d;
      {req, kind, a, d} = VEC[v];
      case (kind)
        2'd0: wr(a, d);
        2'd1: rdChk(int'(req), a, d);
        2'd2: begin
          if (a == 3'd2) sendKbd(d);
          else begin
            @(negedge clk);
            if (a == 3'd0) gpioIn = d[NG-1:0];
            else           tachIn = d[NT-1:0];
            repeat (4) @(negedge clk);
          end
        end
        default: wakeChk(int'(req), d[0]);
      endcase
    end

    // R10: main reset keeps the scan code, clears the rest
    @(negedge clk); rstMainN = 1'b0;
    repeat (2) @(negedge clk); rstMainN = 1'b1;
    repeat (3) @(negedge clk);
    rdChk(10, 3'd6, 8'h5A);
    rdChk(10, 3'd1, 8'h00);
    rdChk(10, 3'd7, 8'h00);
    wakeChk(10, 1'b0);

    // R11: event and write-1 clear in the same cycle
    sendKbd(8'h5A);
    rdChk(11, 3'd1, 8'h20);
    @(negedge clk);
    regAddr = 3'd1; regWrData = 8'h20; regWrEn = 1'b1;
    kbdValid = 1'b1; kbdByte = 8'h5A;
    @(negedge clk);
    regWrEn = 1'b0; kbdValid = 1'b0;
    rdChk(11, 3'd1, 8'h20);
    wr(3'd1, 8'h20);
    rdChk(11, 3'd1, 8'h00);

    // R10: standby reset clears the scan code
    @(negedge clk); rstStbyN = 1'b0;
    repeat (2) @(negedge clk); rstStbyN = 1'b1;
    rdChk(10, 3'd6, 8'h00);

    finishRun();
  end
endmodule